// File: doc/BRIEF.md
# Extended Page Override Sequencer

This block sits next to an instruction decoder. It holds a short window, counted in retired instructions, during which data addressing is overridden. When a page-override prefix instruction retires, the block captures a 10-bit page. That page comes either from a register operand or from an immediate, as the decoder selects. The block also loads a down-counter with the window length, which is 1 to 4 instructions.

While the window is open, the upper ten bits of every long or indirect data address come from the captured page instead of the normal page register. Register-mode and bit-mode special-register accesses are steered to the extended special-register space. Interrupts, peripheral event transfers and class A traps are held off. The window closes when the counted instructions have retired, or at once when a class B trap condition is reported.

Control is a three-state machine:
- **S_IDLE**: no window is open.
- **S_WINDOW**: two or more instructions are still covered.
- **S_FINAL**: exactly one instruction is still covered.

Its transitions are:
- **open** (S_IDLE to S_WINDOW or S_FINAL, chosen by the length).
- **step** (S_WINDOW stays in S_WINDOW on a retire while more than two instructions remain).
- **narrow** (S_WINDOW to S_FINAL on a retire with two remaining).
- **close** (S_FINAL to S_IDLE on a retire).
- **reload** (from S_WINDOW or S_FINAL to S_WINDOW or S_FINAL on a new prefix).
- **abort** (any state to S_IDLE on a class B trap).

Top module: `ext_page_seq`

## Requirements
- R1: Under synchronous active-high reset the window is closed: `irq_lock` and `ext_sfr_sel` are 0 and `eff_addr[23:14]` equals `dpp_page`.
- R2: A prefix retiring (`pfx_valid`=1, `trap_b`=0) with length code `pfx_len_code` = c opens a window of c+1 instructions (code 00 = 1 through 11 = 4). `irq_lock` is 1 from the cycle after the prefix, stays 1 until the (c+1)-th `instr_retire`, and is 0 in the cycle after that retire.
- R3: While the window is open, `eff_addr[23:14]` equals the page captured with the prefix.
- R4: `eff_addr[13:0]` always equals `addr_offset`, combinationally.
- R5: While the window is closed, `eff_addr[23:14]` equals `dpp_page`, combinationally.
- R6: At the prefix, the captured page is `pfx_imm_page` when `pfx_use_imm`=1 and `pfx_reg_page` when `pfx_use_imm`=0.
- R7: `trap_b`=1 at a clock edge closes the window in the next cycle. It takes priority over a prefix in the same cycle, so that prefix opens no window.
- R8: A prefix retiring while a window is open reloads both the count and the page. A prefix takes priority over `instr_retire` in the same cycle.
- R9: Cycles with `instr_retire`=0 do not shorten the window.
- R10: `ext_sfr_sel` is 1 exactly when `irq_lock` is 1.
- R11: While the window is closed, `instr_retire` and `trap_b` alone have no effect: the window stays closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pfx_valid | input | 1 | Page-override prefix retires this cycle |
| pfx_use_imm | input | 1 | 1: page from immediate, 0: page from register operand |
| pfx_reg_page | input | 10 | Page value read from the register operand |
| pfx_imm_page | input | 10 | Page value from the immediate field |
| pfx_len_code | input | 2 | Window length minus one |
| instr_retire | input | 1 | A non-prefix instruction retires this cycle |
| trap_b | input | 1 | Class B trap condition |
| dpp_page | input | 10 | Page from the normal page register |
| addr_offset | input | 14 | Offset of the long or indirect address |
| eff_addr | output | 24 | Effective data address |
| ext_sfr_sel | output | 1 | Steer register and bit accesses to the extended special-register space |
| irq_lock | output | 1 | Hold off interrupts, event transfers and class A traps |

## Verification
The closing functions can meet in one cycle: a class B trap can arrive in the same cycle as a new prefix, and a prefix can coincide with the retire that would have ended the current window. The bench drives each of these collisions on purpose and also lets them occur in a long random run. On every cycle it compares the outputs with a behavioural model in which the trap clears first, then a prefix reloads, then a retire decrements. Each collision is judged by whether the lock is still present one cycle later and by which page then appears in the address.

// File: rtl/ext_page_pkg.sv
package ext_page_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_WINDOW = 2'd1,
        S_FINAL  = 2'd2
    } win_state_t;

endpackage

// File: rtl/ext_page_latch.sv
module ext_page_latch #(
    parameter int PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              use_imm,
    input  logic [PAGE_W-1:0] reg_page,
    input  logic [PAGE_W-1:0] imm_page,
    output logic [PAGE_W-1:0] page_q
);

    logic [PAGE_W-1:0] page_sel;

    always_comb begin
        page_sel = use_imm ? imm_page : reg_page;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (capture) begin
            page_q <= page_sel;
        end
    end

    // R6: a capture takes the operand picked by the source select
    a_r6_page_source: assert property (@(posedge clk) disable iff (rst)
        capture |=> page_q == (($past(use_imm)) ? $past(imm_page) : $past(reg_page)));

    // R8: without a capture the stored page is held
    a_r8_page_hold: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(page_q));

endmodule

// File: rtl/ext_page_counter.sv
module ext_page_counter #(
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [LEN_W-1:0] len_code,
    input  logic             dec,
    output logic [$clog2((1 << LEN_W) + 1)-1:0] remain
);

    localparam int MAX_LEN = 1 << LEN_W;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = CNT_W'(len_code) + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec && remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    // R2: the count never leaves the legal range
    a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
        remain <= CNT_W'(MAX_LEN));

    // R9: no step, no load, no clear leaves the count alone
    a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && !dec) |=> $stable(remain));

    // R7: a clear empties the count
    a_r7_count_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> remain == '0);

endmodule

// File: rtl/ext_page_addr.sv
module ext_page_addr #(
    parameter int PAGE_W = 10,
    parameter int OFS_W  = 14
) (
    input  logic                    active,
    input  logic [PAGE_W-1:0]       ovr_page,
    input  logic [PAGE_W-1:0]       dpp_page,
    input  logic [OFS_W-1:0]        offset,
    output logic [PAGE_W+OFS_W-1:0] eff_addr
);

    logic [PAGE_W-1:0] page_used;

    always_comb begin
        page_used = active ? ovr_page : dpp_page;
        eff_addr  = {page_used, offset};
    end

endmodule

// File: rtl/ext_page_seq.sv
module ext_page_seq
    import ext_page_pkg::*;
#(
    parameter int PAGE_W = 10,
    parameter int OFS_W  = 14,
    parameter int LEN_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pfx_valid,
    input  logic                    pfx_use_imm,
    input  logic [PAGE_W-1:0]       pfx_reg_page,
    input  logic [PAGE_W-1:0]       pfx_imm_page,
    input  logic [LEN_W-1:0]        pfx_len_code,
    input  logic                    instr_retire,
    input  logic                    trap_b,
    input  logic [PAGE_W-1:0]       dpp_page,
    input  logic [OFS_W-1:0]        addr_offset,
    output logic [PAGE_W+OFS_W-1:0] eff_addr,
    output logic                    ext_sfr_sel,
    output logic                    irq_lock
);

    localparam int MAX_LEN = 1 << LEN_W;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    win_state_t        state, state_nx;
    logic [CNT_W-1:0]  remain;
    logic [PAGE_W-1:0] page_q;
    logic              do_load;
    logic              do_step;
    logic              window_on;

    // trap first, then prefix, then ordinary retire
    always_comb begin
        do_load = pfx_valid && !trap_b;
        do_step = instr_retire && !pfx_valid && !trap_b;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (do_load) begin
                    state_nx = (pfx_len_code == '0) ? S_FINAL : S_WINDOW;
                end
            end
            S_WINDOW: begin
                if (trap_b) begin
                    state_nx = S_IDLE;
                end else if (do_load) begin
                    state_nx = (pfx_len_code == '0) ? S_FINAL : S_WINDOW;
                end else if (do_step && remain == CNT_W'(2)) begin
                    state_nx = S_FINAL;
                end
            end
            S_FINAL: begin
                if (trap_b) begin
                    state_nx = S_IDLE;
                end else if (do_load) begin
                    state_nx = (pfx_len_code == '0) ? S_FINAL : S_WINDOW;
                end else if (do_step) begin
                    state_nx = S_IDLE;
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        window_on   = (state != S_IDLE);
        irq_lock    = window_on;
        ext_sfr_sel = window_on;
    end

    ext_page_counter #(.LEN_W(LEN_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .clr      (trap_b),
        .load     (do_load),
        .len_code (pfx_len_code),
        .dec      (do_step),
        .remain   (remain)
    );

    ext_page_latch #(.PAGE_W(PAGE_W)) u_page (
        .clk      (clk),
        .rst      (rst),
        .capture  (do_load),
        .use_imm  (pfx_use_imm),
        .reg_page (pfx_reg_page),
        .imm_page (pfx_imm_page),
        .page_q   (page_q)
    );

    ext_page_addr #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_addr (
        .active   (window_on),
        .ovr_page (page_q),
        .dpp_page (dpp_page),
        .offset   (addr_offset),
        .eff_addr (eff_addr)
    );

    // R2: machine state and the counter agree on whether a window is open
    a_r2_state_matches_count: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) == (remain == '0));

    // R2: a prefix that is not trapped opens the window on the next cycle
    a_r2_open: assert property (@(posedge clk) disable iff (rst)
        (pfx_valid && !trap_b) |=> irq_lock);

    // R2: the last covered retire closes the window
    a_r2_close: assert property (@(posedge clk) disable iff (rst)
        (state == S_FINAL && instr_retire && !pfx_valid && !trap_b) |=> !irq_lock);

    // R7: a class B trap always closes the window
    a_r7_trap_abort: assert property (@(posedge clk) disable iff (rst)
        trap_b |=> !irq_lock);

    // R3: open window drives the captured page
    a_r3_page_override: assert property (@(posedge clk) disable iff (rst)
        irq_lock |-> eff_addr[PAGE_W+OFS_W-1:OFS_W] == page_q);

    // R5: closed window passes the normal page through
    a_r5_page_normal: assert property (@(posedge clk) disable iff (rst)
        !irq_lock |-> eff_addr[PAGE_W+OFS_W-1:OFS_W] == dpp_page);

    // R11: in idle, retires and traps without a prefix keep it closed
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !pfx_valid) |=> state == S_IDLE);

endmodule

// File: tb/sim_ext_page_seq.sv
module sim_ext_page_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        pfx_valid, pfx_use_imm, instr_retire, trap_b;
    logic [9:0]  pfx_reg_page, pfx_imm_page, dpp_page;
    logic [1:0]  pfx_len_code;
    logic [13:0] addr_offset;
    logic [23:0] eff_addr;
    logic        ext_sfr_sel, irq_lock;

    int checks = 0;
    int errors = 0;
    int m_cnt  = 0;
    int m_page = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_page_seq u0 (
        .clk(clk), .rst(rst), .pfx_valid(pfx_valid), .pfx_use_imm(pfx_use_imm),
        .pfx_reg_page(pfx_reg_page), .pfx_imm_page(pfx_imm_page),
        .pfx_len_code(pfx_len_code), .instr_retire(instr_retire), .trap_b(trap_b),
        .dpp_page(dpp_page), .addr_offset(addr_offset), .eff_addr(eff_addr),
        .ext_sfr_sel(ext_sfr_sel), .irq_lock(irq_lock)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL [%s] %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // compare outputs against model, then clock, then advance model
    task automatic tick(input string tag);
        int exp_hi;
        #1;
        exp_hi = (m_cnt != 0) ? m_page : int'(dpp_page);
        check(tag, "R2 irq_lock", int'(irq_lock), (m_cnt != 0) ? 1 : 0);
        check(tag, "R10 ext_sfr_sel", int'(ext_sfr_sel), int'(irq_lock));
        check(tag, (m_cnt != 0) ? "R3 page bits" : "R5 page bits", int'(eff_addr[23:14]), exp_hi);
        check(tag, "R4 offset bits", int'(eff_addr[13:0]), int'(addr_offset));
        @(posedge clk);
        #1;
        if (rst) begin
            m_cnt = 0; m_page = 0;
        end else if (trap_b) begin
            m_cnt = 0;
        end else if (pfx_valid) begin
            m_cnt  = int'(pfx_len_code) + 1;
            m_page = pfx_use_imm ? int'(pfx_imm_page) : int'(pfx_reg_page);
        end else if (instr_retire && m_cnt > 0) begin
            m_cnt = m_cnt - 1;
        end
        @(negedge clk);
        pfx_valid = 0; instr_retire = 0; trap_b = 0;
        dpp_page = 10'($urandom); addr_offset = 14'($urandom);
        pfx_reg_page = 10'($urandom); pfx_imm_page = 10'($urandom);
        pfx_len_code = 2'($urandom); pfx_use_imm = 1'($urandom);
    endtask

    task automatic prefix(input logic imm, input logic [1:0] code);
        pfx_valid = 1; pfx_use_imm = imm; pfx_len_code = code;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; pfx_valid = 0; instr_retire = 0; trap_b = 0; pfx_use_imm = 0;
        pfx_reg_page = 10'h155; pfx_imm_page = 10'h2AA; pfx_len_code = 0;
        dpp_page = 10'h0F0; addr_offset = 14'h1234;
        repeat (2) @(posedge clk);
        @(negedge clk);
        tick("R1"); tick("R1");
        rst = 0;
        tick("R1");

        // R11: retire and trap in idle
        instr_retire = 1; tick("R11");
        trap_b = 1; tick("R11");
        tick("R11");

        // R2, R9: every length, with idle gaps between retires
        for (int c = 0; c < 4; c++) begin
            prefix(1, 2'(c)); tick("R2");
            for (int k = 0; k <= c; k++) begin
                tick("R9");
                instr_retire = 1; tick("R2");
            end
            tick("R2");
        end

        // R6: register source
        prefix(0, 2'd1); pfx_reg_page = 10'h3C3; pfx_imm_page = 10'h001; tick("R6");
        tick("R6");
        instr_retire = 1; tick("R6");
        instr_retire = 1; tick("R6");
        tick("R6");

        // R7: trap mid-window
        prefix(1, 2'd3); tick("R7");
        instr_retire = 1; tick("R7");
        trap_b = 1; instr_retire = 1; tick("R7");
        tick("R7");

        // R7: trap and prefix together, idle and open
        prefix(1, 2'd2); trap_b = 1; tick("R7");
        tick("R7");
        prefix(1, 2'd2); tick("R7");
        prefix(0, 2'd3); trap_b = 1; tick("R7");
        tick("R7");

        // R8: reload mid-window and at the last retire, prefix beats retire
        prefix(1, 2'd1); tick("R8");
        instr_retire = 1; tick("R8");
        prefix(0, 2'd2); instr_retire = 1; tick("R8");
        instr_retire = 1; tick("R8");
        instr_retire = 1; tick("R8");
        prefix(1, 2'd0); instr_retire = 1; tick("R8");
        tick("R8");
        instr_retire = 1; tick("R8");
        tick("R8");

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            pfx_valid    = ($urandom % 6) == 0;
            instr_retire = ($urandom % 2) == 0;
            trap_b       = ($urandom % 15) == 0;
            tick("R8");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule